// File: doc/BRIEF.md
# Debounced 4x4 Key Matrix Scanner

This block reads a grid of sixteen push switches through four column drive lines and four row sense lines. It pulls one column low at a time. The row lines are pulled up, so a row that reads low marks a closed switch at that column. The row lines come from the outside world, so they are resynchronised before the scanner uses them.

The scanner works in two phases. First it insists that the whole matrix is open, and it confirms this with a second scan after a debounce delay. Only then does it look for a closure. A closure it finds is re-checked after another debounce delay, and it is accepted only if the same key is still reported. An accepted key drives a code and a single-cycle strobe. The scanner then goes back to waiting for a full release, so a held key is reported once.

The debounce length is a parameter counted in clock cycles. The column dwell time follows from the synchroniser depth, so that every sample reflects the column currently driven.

Top module: `kpd_scanner`

## Requirements
- R1: While reset is asserted, `col_n` is 4'b1110 (column 0 driven), `key_valid` is 0 and `key_code` is 0.
- R2: Exactly one column is driven low at a time, starting at column 0 and advancing in ascending order. Each column is held for SYNC_STAGES+1 cycles and its rows are sampled in the last of them. A scan stops at the first column that shows a closure or after column 3. A row read as 0 is a closed switch.
- R3: Row inputs pass through a synchroniser of SYNC_STAGES flops (default 2) before any decision, so a change on `row_n` affects a decision no earlier than two edges later.
- R4: After reset the scanner first requires a fully open matrix. A key held through reset and afterwards produces no `key_valid` until it has been released.
- R5: Release is confirmed by an all-open scan, then DEBOUNCE_CYCLES idle cycles with the column lines frozen, then a second scan. Any closure found by either scan restarts the release phase from column 0.
- R6: A closure starts a DEBOUNCE_CYCLES wait and then a re-scan. The key is accepted only if the re-scan's first closure has the same code. Otherwise the press is discarded as a glitch, no strobe is given, and press scanning restarts.
- R7: `key_code` = {column index[1:0], row index[1:0]}. Among several closures, the lowest-numbered column wins, and within that column the lowest-numbered row wins.
- R8: `key_valid` is high for exactly one clock per accepted key. `key_code` changes only in that cycle and holds its value until the next acceptance.
- R9: A key held for a long time yields exactly one strobe; another press is accepted only after a confirmed release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_n | input | 4 | Row sense lines, pulled up, low = closed switch on the driven column |
| col_n | output | 4 | Column drive lines, active low, one at a time |
| key_code | output | 4 | Code of the last accepted key, {column, row} |
| key_valid | output | 1 | One-cycle strobe marking a new accepted key |

## Verification
The bench goes after a key held through reset. A design that skipped the release phase would report that key at once. It presses two keys in different columns and two in one column. A wrong priority order would report the higher column or row. It applies short pulses and a key swap during the press debounce. A design without the same-key re-check would strobe on a glitch or report the first key instead of the second. Contact bounce after release and a long hold both target double reporting. A cycle-exact reference compared every clock also catches an off-by-one dwell or debounce length, or a missing synchroniser stage, as a shifted column sequence or strobe.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
   typedef enum logic [2:0] {
      ST_REL_SCAN = 3'd0,
      ST_REL_WAIT = 3'd1,
      ST_REL_CHK  = 3'd2,
      ST_PRS_SCAN = 3'd3,
      ST_PRS_WAIT = 3'd4,
      ST_PRS_CHK  = 3'd5
   } kpd_state_e;

   function automatic logic is_scan_state(input kpd_state_e s);
      return (s == ST_REL_SCAN) || (s == ST_REL_CHK) ||
             (s == ST_PRS_SCAN) || (s == ST_PRS_CHK);
   endfunction
endpackage

// File: rtl/kpd_sync.sv
module kpd_sync #(
   parameter int               WIDTH   = 4,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   for (genvar s = 0; s < STAGES; s++) begin : g_stg
      logic [WIDTH-1:0] r;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= RST_VAL;
            else        r <= g_stg[s-1].r;
      end
   end
   assign q = g_stg[STAGES-1].r;
endmodule

// File: rtl/kpd_prienc.sv
module kpd_prienc #(
   parameter int WIDTH = 4,
   localparam int IDX_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = WIDTH - 1; i >= 0; i--)
         if (req[i]) idx = IDX_W'(i);
   end
   assign any = |req;
endmodule

// File: rtl/kpd_timer.sv
module kpd_timer #(
   parameter int CYCLES = 8,
   localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   logic [CW-1:0] cnt_q;

   assign done = run && (cnt_q == CW'(CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)            cnt_q <= '0;
      else if (!run || done) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
endmodule

// File: rtl/kpd_scanner.sv
module kpd_scanner
   import kpd_pkg::*;
#(
   parameter int ROWS            = 4,
   parameter int COLS            = 4,
   parameter int SYNC_STAGES     = 2,
   parameter int DEBOUNCE_CYCLES = 250000
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [ROWS-1:0]                      row_n,
   output logic [COLS-1:0]                      col_n,
   output logic [$clog2(COLS)+$clog2(ROWS)-1:0] key_code,
   output logic                                 key_valid
);
   localparam int ROW_W  = $clog2(ROWS);
   localparam int COL_W  = $clog2(COLS);
   localparam int CODE_W = COL_W + ROW_W;
   localparam int DWELL  = SYNC_STAGES + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("kpd_scanner: SYNC_STAGES must be at least 2");
   end
   if (DEBOUNCE_CYCLES < 2) begin : g_bad_deb
      $error("kpd_scanner: DEBOUNCE_CYCLES must be at least 2");
   end
   if (ROWS < 2 || (ROWS & (ROWS - 1)) != 0) begin : g_bad_rows
      $error("kpd_scanner: ROWS must be a power of two");
   end
   if (COLS < 2 || (COLS & (COLS - 1)) != 0) begin : g_bad_cols
      $error("kpd_scanner: COLS must be a power of two");
   end

   kpd_state_e        state_q, state_d;
   logic [COL_W-1:0]  col_q;
   logic [CODE_W-1:0] cand_q, code_q;
   logic              valid_q;

   logic [ROWS-1:0]   rows_s;
   logic              row_any;
   logic [ROW_W-1:0]  row_idx;
   logic              dwell_done, deb_done;
   logic              scanning, waiting, sample, hit, scan_end, wait_end;
   logic              enter_scan, confirm;
   logic [CODE_W-1:0] hit_code;

   kpd_sync #(.WIDTH(ROWS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(row_n), .q(rows_s)
   );

   kpd_prienc #(.WIDTH(ROWS)) u_enc (
      .req(~rows_s), .any(row_any), .idx(row_idx)
   );

   kpd_timer #(.CYCLES(DWELL)) u_dwell (
      .clk(clk), .rst_n(rst_n), .run(scanning), .done(dwell_done)
   );

   kpd_timer #(.CYCLES(DEBOUNCE_CYCLES)) u_deb (
      .clk(clk), .rst_n(rst_n), .run(waiting), .done(deb_done)
   );

   assign scanning = is_scan_state(state_q);
   assign waiting  = (state_q == ST_REL_WAIT) || (state_q == ST_PRS_WAIT);
   assign sample   = scanning && dwell_done;
   assign hit      = sample && row_any;
   assign scan_end = sample && (row_any || (col_q == COL_W'(COLS - 1)));
   assign wait_end = waiting && deb_done;
   assign hit_code = {col_q, row_idx};
   assign confirm  = (state_q == ST_PRS_CHK) && hit && (hit_code == cand_q);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_REL_SCAN: if (scan_end) state_d = hit ? ST_REL_SCAN : ST_REL_WAIT;
         ST_REL_WAIT: if (wait_end) state_d = ST_REL_CHK;
         ST_REL_CHK:  if (scan_end) state_d = hit ? ST_REL_SCAN : ST_PRS_SCAN;
         ST_PRS_SCAN: if (scan_end) state_d = hit ? ST_PRS_WAIT : ST_PRS_SCAN;
         ST_PRS_WAIT: if (wait_end) state_d = ST_PRS_CHK;
         ST_PRS_CHK:  if (scan_end) state_d = confirm ? ST_REL_SCAN : ST_PRS_SCAN;
         default:     state_d = ST_REL_SCAN;
      endcase
   end

   assign enter_scan = (scan_end || wait_end) && is_scan_state(state_d);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         state_q <= ST_REL_SCAN;
         col_q   <= '0;
         cand_q  <= '0;
         code_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (enter_scan)
            col_q <= '0;
         else if (sample && !scan_end)
            col_q <= col_q + 1'b1;
         if (state_q == ST_PRS_SCAN && hit)
            cand_q <= hit_code;
         if (confirm)
            code_q <= hit_code;
         valid_q <= confirm;
      end

   for (genvar c = 0; c < COLS; c++) begin : g_col
      assign col_n[c] = (col_q != COL_W'(c));
   end

   assign key_code  = code_q;
   assign key_valid = valid_q;
endmodule

// File: rtl/kpd_scanner_chk.sv
module kpd_scanner_chk
   import kpd_pkg::*;
#(
   parameter int ROWS = 4,
   parameter int COLS = 4,
   localparam int CODE_W = $clog2(COLS) + $clog2(ROWS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [COLS-1:0]   col_n,
   input logic [CODE_W-1:0] key_code,
   input logic              key_valid,
   input kpd_state_e        state
);
   p_one_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~col_n) == 1);

   p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid |=> !key_valid);

   p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !key_valid |-> $stable(key_code));

   p_accept_after_check_r6: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid |-> $past(state) == ST_PRS_CHK);

   p_frozen_cols_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REL_WAIT && $past(state) == ST_REL_WAIT) |-> $stable(col_n));
endmodule

bind kpd_scanner kpd_scanner_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
   .clk(clk), .rst_n(rst_n), .col_n(col_n), .key_code(key_code),
   .key_valid(key_valid), .state(state_q)
);

// File: tb/tb_kpd_scanner.sv
`timescale 1ns/1ps
module tb_kpd_scanner;
   localparam int ROWS = 4, COLS = 4, SYNC = 2, DEB = 8;
   localparam int DWELL = SYNC + 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] row_n, col_n, key_code;
   logic       key_valid;
   logic [15:0] pressed = '0;

   int checks = 0, fails = 0, pulses = 0;
   logic [3:0] last_code = '0;
   bit done = 0;

   always #4 clk = ~clk;

   kpd_scanner #(.ROWS(ROWS), .COLS(COLS), .SYNC_STAGES(SYNC),
                 .DEBOUNCE_CYCLES(DEB)) dut (
      .clk(clk), .rst_n(rst_n), .row_n(row_n), .col_n(col_n),
      .key_code(key_code), .key_valid(key_valid)
   );

   // physical matrix: a closed switch pulls its row to the driven column
   always_comb begin
      row_n = '1;
      for (int c = 0; c < COLS; c++)
         for (int r = 0; r < ROWS; r++)
            if (pressed[c*ROWS+r] && !col_n[c]) row_n[r] = 1'b0;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // pulse monitor
   always @(negedge clk) if (rst_n && key_valid) begin
      pulses++;
      last_code = key_code;
   end

   // ---------------- cycle-exact reference ----------------
   int       exp_col = 0;
   bit       exp_valid = 0;
   int       exp_code = 0;
   bit [3:0] m_s1 = '1, m_s2 = '1, raw_prev = '1;

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      m_s2 = m_s1;
      m_s1 = raw_prev;
      raw_prev = row_n;
      chk(col_n == ~(4'b1 << exp_col), "R2 column drive", col_n, ~(4'b1 << exp_col) & 4'hF);
      chk(key_valid == exp_valid, "R3 R8 strobe", key_valid, exp_valid);
      chk(key_code == exp_code[3:0], "R7 code", key_code, exp_code);
   endtask

   task automatic m_scan(output bit hit, output int code);
      hit = 0;
      code = 0;
      for (int ci = 0; ci < COLS; ci++) begin
         for (int d = 0; d < DWELL - 1; d++) tick();
         if (m_s2 != 4'hF) begin
            int rr = 0;
            for (int r = ROWS - 1; r >= 0; r--) if (!m_s2[r]) rr = r;
            hit = 1;
            code = ci * ROWS + rr;
            return;
         end
         if (ci < COLS - 1) begin
            exp_col = ci + 1;
            tick();
         end
      end
   endtask

   task automatic m_wait();
      repeat (DEB - 1) tick();
   endtask

   initial begin : ref_model
      bit hit, ok;
      int c1, c2;
      @(posedge rst_n);
      raw_prev = row_n;
      forever begin
         ok = 0;
         while (!ok) begin
            m_scan(hit, c1);
            if (hit) begin exp_col = 0; tick(); end
            else begin
               tick();
               m_wait();
               exp_col = 0; tick();
               m_scan(hit, c1);
               exp_col = 0; tick();
               ok = !hit;
            end
         end
         ok = 0;
         while (!ok) begin
            m_scan(hit, c1);
            if (!hit) begin exp_col = 0; tick(); end
            else begin
               tick();
               m_wait();
               exp_col = 0; tick();
               m_scan(hit, c2);
               if (hit && c2 == c1) begin
                  exp_valid = 1;
                  exp_code = c2;
                  ok = 1;
               end
               exp_col = 0; tick();
               exp_valid = 0;
            end
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic hold(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic set_keys(input logic [15:0] k);
      pressed = k;
   endtask

   initial begin : stim
      int p0;
      set_keys(16'h1 << 5);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(col_n == 4'b1110, "R1 reset col_n", col_n, 4'b1110);
      chk(key_valid == 1'b0, "R1 reset key_valid", key_valid, 0);
      chk(key_code == 4'h0, "R1 reset key_code", key_code, 0);
      rst_n = 1'b1;

      // R4: key held through reset must not be reported
      hold(100);
      chk(pulses == 0, "R4 held-through-reset pulses", pulses, 0);
      set_keys('0); hold(60);
      chk(pulses == 0, "R4 after release pulses", pulses, 0);
      set_keys(16'h1 << 9); hold(60);
      chk(pulses == 1, "R4 first real press pulses", pulses, 1);
      chk(last_code == 4'd9, "R7 code col2 row1", last_code, 9);
      set_keys('0); hold(60);

      // R6: short glitch ignored
      p0 = pulses;
      set_keys(16'h1 << 3); hold(4);
      set_keys('0); hold(60);
      chk(pulses == p0, "R6 glitch pulses", pulses, p0);

      // R7: column priority, then row priority
      set_keys((16'h1 << 6) | (16'h1 << 8)); hold(60);
      chk(pulses == p0 + 1, "R7 two-column pulses", pulses, p0 + 1);
      chk(last_code == 4'd6, "R7 lowest column wins", last_code, 6);
      set_keys('0); hold(60);
      set_keys((16'h1 << 13) | (16'h1 << 15)); hold(60);
      chk(last_code == 4'd13, "R7 lowest row wins", last_code, 13);
      set_keys('0); hold(60);

      // R9: long hold gives one strobe
      p0 = pulses;
      set_keys(16'h1 << 0); hold(200);
      chk(pulses == p0 + 1, "R9 long hold pulses", pulses, p0 + 1);
      chk(last_code == 4'd0, "R9 long hold code", last_code, 0);
      set_keys('0); hold(60);

      // R5: bouncing release does not produce extra strobes
      p0 = pulses;
      set_keys(16'h1 << 10); hold(60);
      set_keys('0); hold(2);
      set_keys(16'h1 << 10); hold(2);
      set_keys('0); hold(2);
      set_keys(16'h1 << 10); hold(2);
      set_keys('0); hold(80);
      chk(pulses == p0 + 1, "R5 bounce pulses", pulses, p0 + 1);
      chk(last_code == 4'd10, "R5 bounce code", last_code, 10);

      // R6: key swapped during press debounce reports the second key
      p0 = pulses;
      set_keys(16'h1 << 2); hold(6);
      set_keys(16'h1 << 7); hold(60);
      chk(pulses == p0 + 1, "R6 swap pulses", pulses, p0 + 1);
      chk(last_code == 4'd7, "R6 swap code", last_code, 7);
      set_keys('0); hold(40);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule